// File: doc/BRIEF.md
# Separable Switch Allocator

This block decides, every cycle, which flits cross the crossbar of a virtual-channel router. It works in two stages.

In the first stage, every input port runs its own round-robin arbiter over its virtual channels and keeps one requesting channel. That channel then asks for the output port it has selected. In the second stage, every output port runs its own round-robin arbiter over the input ports that ask for it and grants one of them.

The grants are registered. For each output port they report a valid flag, the winning input port and the winning virtual channel. Credit checks, VC allocation and the crossbar itself live outside this block.

Each round-robin pointer moves only in a cycle where its own arbiter produces a winner. This keeps waiting times even under heavy load. It also means a pointer does not drift while no request is present.

Top module: `sw_alloc_sep`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, no grant is valid. All round-robin pointers restart at 0, so the first arbitration favours VC 0 and input port 0.
- R2: For each input port, the stage-1 winner is the first requesting VC found in circular order. The search starts at that port's pointer and wraps modulo NUM_VC. Each port forwards at most one winner per cycle.
- R3: A stage-1 pointer changes only in a cycle where its port has a winner. With no requesting VC it keeps its value.
- R4: When a stage-1 pointer advances, it becomes its stored value plus one, wrapping to 0 at NUM_VC. The index of the winning VC plays no part in the new value.
- R5: The stage-1 winner requests the output named by its selector. Request bit i*NUM_VC+v of vc_req_i belongs to input i, VC v. That VC's output index is the field vc_out_i[(i*NUM_VC+v)*OW +: OW], where OW = clog2(NUM_OUT).
- R6: For each output port, the granted input is the first input whose stage-1 winner asks for that output. The search is in circular order, starting at the output's pointer and wrapping modulo NUM_IN.
- R7: A stage-2 pointer advances by one, wrapping to 0 at NUM_IN, only in a cycle where its output grants an input. Otherwise it holds.
- R8: Grants appear on the clock edge that samples the requests. For output o they show gnt_valid_o[o], the input on gnt_in_o[o*IW +: IW] and the VC on gnt_vc_o[o*VW +: VW]. An output with no request shows no valid grant.
- R9: An input whose stage-1 winner loses at stage 2 gets no grant that cycle. Its stage-1 pointer still advances. In the next cycle it arbitrates again from the new pointer.
- R10: No input port is granted by more than one output port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vc_req_i | input | NUM_IN*NUM_VC | Per-VC request valid bits |
| vc_out_i | input | NUM_IN*NUM_VC*OW | Per-VC desired output port |
| gnt_valid_o | output | NUM_OUT | Grant valid per output port |
| gnt_in_o | output | NUM_OUT*IW | Granted input port per output |
| gnt_vc_o | output | NUM_OUT*VW | Granted VC per output |

## Verification
The hardest case to reach is the one that tells the two pointer rules apart. A stage-1 pointer must step from its stored value and not from the winner's index (R4). It must also keep moving when its winner loses at stage 2 (R9).

The stimulus first leaves a port's pointer behind a lone request on a higher VC. It then raises two VCs whose winner differs under the two update rules. For the loss case, two inputs contend for one output while the losing input has several VCs pending. The winning VC it shows in the following cycle then reveals where its pointer moved.

// File: rtl/sw_alloc_pkg.sv
package sw_alloc_pkg;
  localparam int unsigned DEF_NUM_IN  = 4;
  localparam int unsigned DEF_NUM_OUT = 4;
  localparam int unsigned DEF_NUM_VC  = 4;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = sw_alloc_pkg::idx_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] start_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < int'(N); k++) begin
      int j;
      j = (int'(start_i) + k) % int'(N);
      if (!valid_o && req_i[j]) begin
        valid_o = 1'b1;
        idx_o   = IW'(j);
      end
    end
  end

  // R2 R6
  pick_is_requester_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[idx_o]);

  // R2 R6
  pick_when_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> valid_o);
endmodule

// File: rtl/rr_ptr.sv
module rr_ptr #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = sw_alloc_pkg::idx_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == IW'(N-1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // R3 R7
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));

  // R4 R7
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (32'(ptr_q) < N) && (ptr_q != $past(ptr_q) || N == 1));
endmodule

// File: rtl/sa_in_port.sv
module sa_in_port #(
  parameter int unsigned NUM_VC  = 4,
  parameter int unsigned NUM_OUT = 4,
  localparam int unsigned VW = sw_alloc_pkg::idx_w(NUM_VC),
  localparam int unsigned OW = sw_alloc_pkg::idx_w(NUM_OUT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_VC-1:0]    req_i,
  input  logic [NUM_VC*OW-1:0] sel_i,
  output logic                 win_o,
  output logic [VW-1:0]        win_vc_o,
  output logic [OW-1:0]        win_out_o
);
  logic [VW-1:0] ptr;

  rr_pick #(.N(NUM_VC)) u_pick (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .start_i(ptr),
    .valid_o(win_o), .idx_o(win_vc_o));

  // stage-1 pointer moves on a stage-1 win, whatever stage 2 decides
  rr_ptr #(.N(NUM_VC)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(win_o), .ptr_o(ptr));

  assign win_out_o = sel_i[32'(win_vc_o)*OW +: OW];

  // R3
  vc_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> $stable(ptr));
endmodule

// File: rtl/sa_out_port.sv
module sa_out_port #(
  parameter int unsigned NUM_IN = 4,
  localparam int unsigned IW = sw_alloc_pkg::idx_w(NUM_IN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] req_i,
  output logic              gnt_o,
  output logic [IW-1:0]     gnt_in_o
);
  logic [IW-1:0] ptr;

  rr_pick #(.N(NUM_IN)) u_pick (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .start_i(ptr),
    .valid_o(gnt_o), .idx_o(gnt_in_o));

  rr_ptr #(.N(NUM_IN)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(gnt_o), .ptr_o(ptr));

  // R7
  out_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> $stable(ptr));
endmodule

// File: rtl/sw_alloc_sep.sv
module sw_alloc_sep #(
  parameter int unsigned NUM_IN  = sw_alloc_pkg::DEF_NUM_IN,
  parameter int unsigned NUM_OUT = sw_alloc_pkg::DEF_NUM_OUT,
  parameter int unsigned NUM_VC  = sw_alloc_pkg::DEF_NUM_VC,
  localparam int unsigned IW = sw_alloc_pkg::idx_w(NUM_IN),
  localparam int unsigned OW = sw_alloc_pkg::idx_w(NUM_OUT),
  localparam int unsigned VW = sw_alloc_pkg::idx_w(NUM_VC),
  localparam int unsigned NREQ = NUM_IN * NUM_VC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NREQ-1:0]    vc_req_i,
  input  logic [NREQ*OW-1:0] vc_out_i,
  output logic [NUM_OUT-1:0] gnt_valid_o,
  output logic [NUM_OUT*IW-1:0] gnt_in_o,
  output logic [NUM_OUT*VW-1:0] gnt_vc_o
);
  logic [NUM_IN-1:0]                win;
  logic [NUM_IN-1:0][VW-1:0]        win_vc;
  logic [NUM_IN-1:0][OW-1:0]        win_out;
  logic [NUM_OUT-1:0][NUM_IN-1:0]   out_req;
  logic [NUM_OUT-1:0]               out_gnt;
  logic [NUM_OUT-1:0][IW-1:0]       out_in;

  logic [NUM_OUT-1:0]               gv_q;
  logic [NUM_OUT-1:0][IW-1:0]       gi_q;
  logic [NUM_OUT-1:0][VW-1:0]       gc_q;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    sa_in_port #(.NUM_VC(NUM_VC), .NUM_OUT(NUM_OUT)) u_in (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (vc_req_i[i*NUM_VC +: NUM_VC]),
      .sel_i    (vc_out_i[i*NUM_VC*OW +: NUM_VC*OW]),
      .win_o    (win[i]),
      .win_vc_o (win_vc[i]),
      .win_out_o(win_out[i]));
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    for (genvar i = 0; i < NUM_IN; i++) begin : g_req
      assign out_req[o][i] = win[i] && (win_out[i] == OW'(o));
    end

    sa_out_port #(.NUM_IN(NUM_IN)) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (out_req[o]),
      .gnt_o   (out_gnt[o]),
      .gnt_in_o(out_in[o]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gv_q[o] <= 1'b0;
        gi_q[o] <= '0;
        gc_q[o] <= '0;
      end else begin
        gv_q[o] <= out_gnt[o];
        gi_q[o] <= out_in[o];
        gc_q[o] <= win_vc[out_in[o]];
      end
    end

    assign gnt_valid_o[o]          = gv_q[o];
    assign gnt_in_o[o*IW +: IW]    = gi_q[o];
    assign gnt_vc_o[o*VW +: VW]    = gc_q[o];

    // R8
    no_req_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|out_req[o]) |=> !gnt_valid_o[o]);
  end

  // previous-cycle copy of the request inputs, for checking only
  logic [NREQ-1:0]    req_d;
  logic [NREQ*OW-1:0] sel_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d <= '0;
      sel_d <= '0;
    end else begin
      req_d <= vc_req_i;
      sel_d <= vc_out_i;
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk_out
    logic [31:0] flat;
    assign flat = 32'(gi_q[o]) * NUM_VC + 32'(gc_q[o]);

    // R5 R8
    gnt_legit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_valid_o[o] |-> req_d[flat] && (sel_d[flat*OW +: OW] == OW'(o)));
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk_in
    logic [NUM_OUT-1:0] hit;
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_hit
      assign hit[o] = gv_q[o] && (gi_q[o] == IW'(i));
    end

    // R10
    one_out_per_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hit));
  end
endmodule

// File: tb/tb_sw_alloc_sep.sv
module tb_sw_alloc_sep;
  localparam int NI = 4, NO = 4, NV = 4;
  localparam int IW = 2, OW = 2, VW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NI*NV-1:0]    vc_req;
  logic [NI*NV*OW-1:0] vc_out;
  logic [NO-1:0]       gnt_valid;
  logic [NO*IW-1:0]    gnt_in;
  logic [NO*VW-1:0]    gnt_vc;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int p1 [NI];
  int p2 [NO];
  int seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_alloc_sep #(.NUM_IN(NI), .NUM_OUT(NO), .NUM_VC(NV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .vc_req_i(vc_req), .vc_out_i(vc_out),
    .gnt_valid_o(gnt_valid), .gnt_in_o(gnt_in), .gnt_vc_o(gnt_vc));

  task automatic set_req(input int i, input int v, input int o);
    vc_req[i*NV+v] = 1'b1;
    vc_out[(i*NV+v)*OW +: OW] = OW'(o);
  endtask

  task automatic clear_req();
    vc_req = '0;
    vc_out = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    clear_req();
    for (int k = 0; k < NI; k++) p1[k] = 0;
    for (int k = 0; k < NO; k++) p2[k] = 0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  // one arbitration cycle: model expected grants, clock, compare
  task automatic step(input string tag);
    bit w [NI];
    int wv [NI];
    int wo [NI];
    bit ev [NO];
    int ei [NO];
    int ec [NO];
    bit bad = 0;
    for (int i = 0; i < NI; i++) begin
      w[i] = 0; wv[i] = 0; wo[i] = 0;
      for (int k = 0; k < NV; k++) begin
        int v = (p1[i] + k) % NV;
        if (!w[i] && vc_req[i*NV+v]) begin
          w[i] = 1; wv[i] = v; wo[i] = int'(vc_out[(i*NV+v)*OW +: OW]);
        end
      end
    end
    for (int o = 0; o < NO; o++) begin
      ev[o] = 0; ei[o] = 0; ec[o] = 0;
      for (int k = 0; k < NI; k++) begin
        int i = (p2[o] + k) % NI;
        if (!ev[o] && w[i] && wo[i] == o) begin
          ev[o] = 1; ei[o] = i; ec[o] = wv[i];
        end
      end
    end
    @(posedge clk);
    #1;
    n_tests++;
    for (int o = 0; o < NO; o++) begin
      int ai = int'(gnt_in[o*IW +: IW]);
      int ac = int'(gnt_vc[o*VW +: VW]);
      if (gnt_valid[o] !== ev[o] || (ev[o] && (ai != ei[o] || ac != ec[o]))) begin
        $display("FAIL %s out%0d: got v=%0b in=%0d vc=%0d, exp v=%0b in=%0d vc=%0d",
                 tag, o, gnt_valid[o], ai, ac, ev[o], ei[o], ec[o]);
        bad = 1;
      end
    end
    if (bad) n_fail++;
    for (int i = 0; i < NI; i++) if (w[i]) p1[i] = (p1[i] + 1) % NV;
    for (int o = 0; o < NO; o++) if (ev[o]) p2[o] = (p2[o] + 1) % NI;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1;
    n_tests++;
    if (gnt_valid !== '0) begin
      $display("FAIL R1 during reset: got %b exp 0", gnt_valid);
      n_fail++;
    end
    do_reset();
    step("R1 first cycle idle");
    // all VCs of all inputs to out0: expect in0 vc0
    for (int i = 0; i < NI; i++) for (int v = 0; v < NV; v++) set_req(i, v, 0);
    step("R1 restart at in0 vc0");
    clear_req();
  endtask

  task automatic t_single();
    do_reset();
    set_req(2, 3, 1);
    step("R5 R8 single request");
    clear_req();
    step("R8 no request no grant");
  endtask

  task automatic t_vc_rotation();
    do_reset();
    for (int v = 0; v < NV; v++) set_req(0, v, 0);
    repeat (6) step("R2 VC rotation");
    clear_req();
    repeat (3) step("R3 idle hold");
    for (int v = 0; v < NV; v++) set_req(0, v, 0);
    step("R3 resume after idle");
    clear_req();
  endtask

  task automatic t_stored_ptr();
    do_reset();
    set_req(1, 2, 2);
    step("R4 lone VC2 from ptr0");
    clear_req();
    set_req(1, 2, 2);
    set_req(1, 3, 2);
    step("R4 step from stored value");
    clear_req();
    set_req(1, 3, 0);
    step("R4 wrap setup");
    step("R4 wrap setup");
    clear_req();
    set_req(1, 0, 0);
    set_req(1, 3, 0);
    step("R4 wrap at NUM_VC");
    clear_req();
  endtask

  task automatic t_contention();
    do_reset();
    for (int i = 0; i < NI; i++) set_req(i, 0, 3);
    repeat (6) step("R6 R7 output rotation");
    clear_req();
    step("R7 idle hold");
    set_req(3, 1, 3);
    set_req(1, 1, 3);
    step("R7 resume from held ptr");
    clear_req();
  endtask

  task automatic t_loss();
    do_reset();
    set_req(0, 0, 0);
    set_req(0, 1, 0);
    set_req(0, 2, 0);
    set_req(1, 0, 0);
    repeat (4) step("R9 stage-2 loss");
    clear_req();
  endtask

  task automatic t_parallel();
    do_reset();
    for (int i = 0; i < NI; i++) set_req(i, i, NO - 1 - i);
    step("R10 parallel distinct outputs");
    clear_req();
  endtask

  task automatic t_random();
    do_reset();
    for (int c = 0; c < 300; c++) begin
      for (int k = 0; k < NI*NV; k++) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        vc_req[k] = seed[3] & seed[9];
        vc_out[k*OW +: OW] = OW'(seed[21:20]);
      end
      step("R10 random traffic");
    end
    clear_req();
  endtask

  initial begin
    clear_req();
    t_reset();
    t_single();
    t_vc_rotation();
    t_stored_ptr();
    t_contention();
    t_loss();
    t_parallel();
    t_random();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule